// File: doc/BRIEF.md
# Line-Rate Reconfiguration Sequencer

This block retunes one serial transceiver channel between a 1G and a 10G Ethernet line rate. It runs on a free-running stable clock and watches a rate-select line from the user. When the synchronized select no longer matches the rate the channel is set up for, it walks a computed table of transceiver registers for the new rate. It updates each register by a read-modify-write over the dynamic reconfiguration port (DRP). When the last register is written, it holds the channel in reset for a fixed number of cycles. It then waits for the PLL that serves the new rate to lock.

A busy flag covers the whole sequence, and a one-cycle done pulse marks the return to idle. The data-path multiplexer, the coding layers and the transceiver itself sit outside the block.

Top module: `rate_switch_ctrl`

## Requirements
- R1: During and right after reset, drpEn, drpWe, chanRst, busy and done are low, and drpAddr and drpDi are zero. The block takes the channel to be at 10G.
- R2: A configured rate of 1G (select value 1) waits on cpllLock. A configured rate of 10G (select value 0) waits on qpllLock. After a sequence, busy stays high until the matching lock input is high, whatever the state of the other lock input.
- R3: rateSel passes through a two-flop synchronizer. While idle, a synchronized value that differs from the configured rate starts a sequence for that value. A change that arrives during a sequence is serviced after the return to idle. An unchanged select starts nothing.
- R4: Entries are visited from k = 0 upward, for ENTRIES_1G entries at 1G and ENTRIES_10G entries at 10G. Each entry is read and then written at the same address: 0x100 + 4k for 1G, or 0x101 + 4k for 10G.
- R5: The written word is the read word with bits [4(k mod 4)+3 : 4(k mod 4)] replaced by the new nibble and all other bits kept. The nibble is (k+1) mod 16 for 1G and 15 - k for 10G.
- R6: drpEn is a one-cycle pulse per access. drpWe is high only together with drpEn on write accesses. No new access is issued before drpRdy acknowledges the previous one.
- R7: After the last write acknowledge, chanRst is high for exactly RST_CYCLES (16) consecutive cycles, with no DRP access during that time.
- R8: busy rises when a sequence starts and falls once the matching lock is seen after the channel reset. In the same cycle that busy falls, done pulses for exactly one cycle.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| rateSel | input | 1 | Requested rate, 1 = 1G, 0 = 10G (asynchronous) |
| cpllLock | input | 1 | Channel PLL lock (1G) |
| qpllLock | input | 1 | Quad PLL lock (10G) |
| drpEn | output | 1 | DRP access strobe |
| drpWe | output | 1 | DRP write enable |
| drpAddr | output | 10 | DRP register address |
| drpDi | output | 16 | DRP write data |
| drpDo | input | 16 | DRP read data |
| drpRdy | input | 1 | DRP access acknowledge |
| chanRst | output | 1 | Transceiver channel reset pulse |
| busy | output | 1 | Reconfiguration in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with four entries per rate and a 16-cycle channel reset. With four entries, every nibble position of the modify mask is exercised for both rates, and the read-back contents of a modelled register file can be compared against the formula. The DRP model answers three cycles after each strobe, which exposes any access issued before its acknowledge. Holding one lock low while the other is high shows which PLL the lock wait listens to, and a select change made mid-sequence shows that the request is serviced afterwards.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  typedef struct packed {
    logic loadStart;
    logic rateOneG;
    logic issueRead;
    logic captureRead;
    logic issueWrite;
    logic advance;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_INIT, S_LOCK, S_IDLE, S_READ, S_WAIT_RD, S_WRITE, S_WAIT_WR, S_CHRST
  } ctrlState_t;
endpackage

// File: rtl/rsw_sync.sv
module rsw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= rst ? 1'b0 : din;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= rst ? 1'b0 : chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsw_datapath.sv
module rsw_datapath
  import rsw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int ENTRIES_1G  = 4,
  parameter int ENTRIES_10G = 4,
  parameter int ADDR_BASE   = 'h100,
  parameter int ADDR_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] drpDo,
  output logic              drpEn,
  output logic              drpWe,
  output logic [ADDR_W-1:0] drpAddr,
  output logic [DATA_W-1:0] drpDi,
  output logic              lastEntry
);
  localparam int MAX_ENTRIES = (ENTRIES_1G > ENTRIES_10G) ? ENTRIES_1G : ENTRIES_10G;
  localparam int IDX_W       = $clog2(MAX_ENTRIES + 1);

  logic             rateReg;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] remaining;

  logic [ADDR_W-1:0] entryAddr;
  logic [DATA_W-1:0] changeMask;
  logic [DATA_W-1:0] newBits;
  logic [3:0]        newNibble;
  logic [4:0]        shiftAmt;

  // Table entry computed from the rate and entry index
  always_comb begin
    shiftAmt   = {1'b0, idx[1:0], 2'b00};
    entryAddr  = ADDR_W'(ADDR_BASE) + ADDR_W'(idx) * ADDR_W'(ADDR_STRIDE)
                 + (rateReg ? ADDR_W'(0) : ADDR_W'(1));
    newNibble  = rateReg ? 4'(idx + 1'b1) : 4'(4'hF - 4'(idx));
    changeMask = {{(DATA_W-4){1'b0}}, 4'hF} << shiftAmt;
    newBits    = {{(DATA_W-4){1'b0}}, newNibble} << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rateReg   <= 1'b0;
      idx       <= '0;
      remaining <= '0;
      drpEn     <= 1'b0;
      drpWe     <= 1'b0;
      drpAddr   <= '0;
      drpDi     <= '0;
    end else begin
      drpEn <= strobe.issueRead | strobe.issueWrite;
      drpWe <= strobe.issueWrite;
      if (strobe.loadStart) begin
        rateReg   <= strobe.rateOneG;
        idx       <= '0;
        remaining <= strobe.rateOneG ? IDX_W'(ENTRIES_1G) : IDX_W'(ENTRIES_10G);
      end
      if (strobe.advance) begin
        idx       <= idx + 1'b1;
        remaining <= remaining - 1'b1;
      end
      if (strobe.issueRead) drpAddr <= entryAddr;
      if (strobe.captureRead) drpDi <= (drpDo & ~changeMask) | newBits;
    end
  end

  assign lastEntry = (remaining == IDX_W'(1));

  p_en_pulse_r6: assert property (@(posedge clk) disable iff (rst) drpEn |=> !drpEn)
    else $error("drpEn longer than one cycle");
  p_we_with_en_r6: assert property (@(posedge clk) disable iff (rst) drpWe |-> drpEn)
    else $error("drpWe without drpEn");
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst) !$stable(drpAddr) |-> drpEn)
    else $error("address moved between accesses");
endmodule

// File: rtl/rsw_ctrl.sv
module rsw_ctrl
  import rsw_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      selSync,
  input  logic      cpllLock,
  input  logic      qpllLock,
  input  logic      drpRdy,
  input  logic      lastEntry,
  output dpStrobe_t strobe,
  output logic      chanRst,
  output logic      busy,
  output logic      done
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  ctrlState_t state, nextState;
  logic            appliedRate;
  logic [RC_W-1:0] rstCnt;
  logic            lockOk;

  assign lockOk = appliedRate ? cpllLock : qpllLock;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_INIT:    nextState = S_LOCK;
      S_LOCK:    if (lockOk) nextState = S_IDLE;
      S_IDLE: begin
        if (selSync != appliedRate) begin
          strobe.loadStart = 1'b1;
          strobe.rateOneG  = selSync;
          nextState        = S_READ;
        end
      end
      S_READ: begin
        strobe.issueRead = 1'b1;
        nextState        = S_WAIT_RD;
      end
      S_WAIT_RD: begin
        if (drpRdy) begin
          strobe.captureRead = 1'b1;
          nextState          = S_WRITE;
        end
      end
      S_WRITE: begin
        strobe.issueWrite = 1'b1;
        nextState         = S_WAIT_WR;
      end
      S_WAIT_WR: begin
        if (drpRdy) begin
          if (lastEntry) nextState = S_CHRST;
          else begin
            strobe.advance = 1'b1;
            nextState      = S_READ;
          end
        end
      end
      S_CHRST: if (rstCnt == RC_W'(RST_CYCLES - 1)) nextState = S_LOCK;
      default:   nextState = S_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_INIT;
      appliedRate <= 1'b0;
      rstCnt      <= '0;
      chanRst     <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
    end else begin
      state   <= nextState;
      chanRst <= (nextState == S_CHRST);
      done    <= 1'b0;
      rstCnt  <= (state == S_CHRST) ? rstCnt + 1'b1 : '0;
      if (strobe.loadStart) begin
        appliedRate <= selSync;
        busy        <= 1'b1;
      end
      if (state == S_LOCK && lockOk && busy) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst) done |-> !busy)
    else $error("done while busy");
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done)
    else $error("done longer than one cycle");
  p_rst_in_seq_r7: assert property (@(posedge clk) disable iff (rst) chanRst |-> busy)
    else $error("channel reset outside a sequence");
endmodule

// File: rtl/rate_switch_ctrl.sv
module rate_switch_ctrl
  import rsw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int ENTRIES_1G  = 4,
  parameter int ENTRIES_10G = 4,
  parameter int RST_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rateSel,
  input  logic              cpllLock,
  input  logic              qpllLock,
  output logic              drpEn,
  output logic              drpWe,
  output logic [ADDR_W-1:0] drpAddr,
  output logic [DATA_W-1:0] drpDi,
  input  logic [DATA_W-1:0] drpDo,
  input  logic              drpRdy,
  output logic              chanRst,
  output logic              busy,
  output logic              done
);
  logic      selSync;
  logic      lastEntry;
  dpStrobe_t strobe;

  rsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rateSel), .dout(selSync)
  );

  rsw_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .selSync(selSync), .cpllLock(cpllLock),
    .qpllLock(qpllLock), .drpRdy(drpRdy), .lastEntry(lastEntry),
    .strobe(strobe), .chanRst(chanRst), .busy(busy), .done(done)
  );

  rsw_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ENTRIES_1G(ENTRIES_1G), .ENTRIES_10G(ENTRIES_10G)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .drpDo(drpDo),
    .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr), .drpDi(drpDi),
    .lastEntry(lastEntry)
  );

  p_no_access_in_rst_r7: assert property (@(posedge clk) disable iff (rst) chanRst |-> !drpEn)
    else $error("DRP access during channel reset");
endmodule

// File: tb/tb_rate_switch_ctrl.sv
module tb_rate_switch_ctrl;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rateSel = 1'b0;
  logic        cpllLock = 1'b0;
  logic        qpllLock = 1'b0;
  logic        drpEn, drpWe, chanRst, busy, done;
  logic [9:0]  drpAddr;
  logic [15:0] drpDi;
  logic [15:0] drpDo = '0;
  logic        drpRdy = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rate_switch_ctrl dut (
    .clk(clk), .rst(rst), .rateSel(rateSel), .cpllLock(cpllLock),
    .qpllLock(qpllLock), .drpEn(drpEn), .drpWe(drpWe), .drpAddr(drpAddr),
    .drpDi(drpDi), .drpDo(drpDo), .drpRdy(drpRdy), .chanRst(chanRst),
    .busy(busy), .done(done)
  );

  // DRP register file model, acknowledges three cycles after a strobe
  logic [15:0] mem [0:1023];
  logic [9:0]  pendAddr = '0;
  int          pendCnt = 0;
  initial for (int i = 0; i < 1024; i++) mem[i] = 16'h3C00 ^ 16'(i);

  always @(posedge clk) begin
    if (drpEn) begin
      if (drpWe) mem[drpAddr] <= drpDi;
      pendAddr <= drpAddr;
      pendCnt  <= 3;
    end else if (pendCnt != 0) pendCnt <= pendCnt - 1;
    drpRdy <= (pendCnt == 1) && !drpEn;
    drpDo  <= mem[pendAddr];
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitors sampled away from the active edge
  int  enCnt = 0, wrCnt = 0, rstRun = 0, lastRstLen = 0, doneRun = 0, doneCnt = 0;
  bit  outstanding = 0, prevEn = 0;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (drpEn) begin
        enCnt++;
        if (drpWe) wrCnt++;
        if (prevEn) chk(0, "R6 enable width", 2, 1);
        if (outstanding) chk(0, "R6 access before ack", 1, 0);
        if (chanRst) chk(0, "R7 access during reset", 1, 0);
        outstanding = 1;
      end else if (drpRdy) outstanding = 0;
      if (drpWe && !drpEn) chk(0, "R6 write enable alone", 1, 0);
      prevEn = drpEn;
      if (chanRst) rstRun++;
      else if (rstRun != 0) begin lastRstLen = rstRun; rstRun = 0; end
      if (done) begin doneRun++; doneCnt++; if (busy) chk(0, "R8 done with busy", 1, 0); end
      else begin if (doneRun > 1) chk(0, "R8 done width", doneRun, 1); doneRun = 0; end
    end
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      report();
    end
  end

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic logic [15:0] expWord(input bit oneG, input int k);
    logic [9:0]  a = 10'(32'h100 + 4 * k + (oneG ? 0 : 1));
    logic [15:0] m = 16'h000F << (4 * (k % 4));
    logic [3:0]  nib = oneG ? 4'(k + 1) : 4'(15 - k);
    return ((16'h3C00 ^ 16'(a)) & ~m) | (16'(nib) << (4 * (k % 4)));
  endfunction

  task automatic waitDoneCount(input int target);
    int w = 0;
    while (doneCnt < target && w < 5000) begin @(negedge clk); w++; end
    chk(doneCnt >= target, "R8 done reached", doneCnt, target);
  endtask

  task automatic checkTable(input bit oneG, input string tag);
    for (int k = 0; k < N; k++) begin
      int a = 'h100 + 4 * k + (oneG ? 0 : 1);
      chk(mem[a] == expWord(oneG, k), tag, mem[a], expWord(oneG, k));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!drpEn && !drpWe && !chanRst && !busy && !done, "R1 control outputs", {drpEn, drpWe, chanRst, busy, done}, 0);
    chk(drpAddr == 0 && drpDi == 0, "R1 address and data", {drpAddr, drpDi}, 0);
  endtask

  task automatic t_no_change();
    qpllLock = 1; cpllLock = 0;
    rst = 0;
    repeat (60) @(negedge clk);
    chk(enCnt == 0, "R3 no access with select unchanged", enCnt, 0);
    chk(!busy && doneCnt == 0, "R1 starts at 10G, no sequence", {busy, 8'(doneCnt)}, 0);
  endtask

  task automatic t_to_1g();
    int d = 0;
    rateSel = 1;
    @(negedge clk);
    chk(!busy && enCnt == 0, "R3 sync delay", {busy, 8'(enCnt)}, 0);
    while (!chanRst && d < 2000) begin @(negedge clk); d++; end
    chk(busy, "R8 busy during sequence", busy, 1);
    chk(enCnt == 2 * N && wrCnt == N, "R4 access count", enCnt, 2 * N);
    checkTable(1, "R5 1G words");
    chk(mem['h101] == (16'h3C00 ^ 16'h101), "R4 10G address untouched", mem['h101], 16'h3C00 ^ 16'h101);
    repeat (60) @(negedge clk);
    chk(lastRstLen == 16, "R7 reset width", lastRstLen, 16);
    chk(busy && doneCnt == 0, "R2 waits for channel PLL", busy, 1);
    cpllLock = 1;
    waitDoneCount(1);
    @(negedge clk);
    chk(!busy, "R8 busy cleared", busy, 0);
  endtask

  task automatic t_back_with_request();
    int d = 0;
    int base = enCnt;
    rateSel = 0; qpllLock = 1; cpllLock = 1;
    while (!busy && d < 100) begin @(negedge clk); d++; end
    chk(busy, "R3 toggle to 10G starts", busy, 1);
    repeat (5) @(negedge clk);
    rateSel = 1;
    waitDoneCount(2);
    checkTable(0, "R5 10G words");
    waitDoneCount(3);
    chk(enCnt - base == 4 * N, "R3 queued request serviced", enCnt - base, 4 * N);
    checkTable(1, "R5 1G words rewritten");
    repeat (60) @(negedge clk);
    chk(doneCnt == 3 && !busy, "R3 nothing further", doneCnt, 3);
  endtask

  task automatic t_lock_10g();
    int base = doneCnt;
    cpllLock = 1; qpllLock = 0;
    rateSel = 0;
    repeat (400) @(negedge clk);
    chk(busy && doneCnt == base, "R2 waits for quad PLL", busy, 1);
    qpllLock = 1;
    waitDoneCount(base + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_change();
    t_to_1g();
    t_back_with_request();
    t_lock_10g();
    repeat (5) @(negedge clk);
    report();
  end
endmodule